// File: doc/BRIEF.md
# SPI byte-queue front end with dual interrupt router

This block is the host-facing side of a packet radio's data path. A host drives one SPI bus carrying two active-low selects. One select reaches a 16-byte queue and the other reaches a small set of settings. The queue changes direction with the radio's mode. In receive mode the demodulator side stores bytes and the host drains them over SPI. In transmit mode the host fills the queue over SPI and the modulator side takes bytes from its head.

Two interrupt pins tell the host when to move data. Each pin has its own source map for receive mode and another for transmit mode, and all four maps sit in one routing byte. The sources are queue flags, a pulse for each stored byte, and three status lines from the analog side (start-pattern hit, signal-strength alarm, transmit finished). Those three arrive as plain inputs.

All SPI lines are brought into the system clock domain before use. The block only ever acts as a slave and never drives the serial clock.

Top module: `spi_irq_router`

## Requirements
- R1: When both selects are low together, the settings select takes priority: the bytes go to the settings and the queue is not touched.
- R2: SPI is mode 0 with the most significant bit first. A byte takes effect only when its eighth rising clock edge arrives while the select is still low. A partial byte is discarded, and the next transaction starts a fresh byte.
- R3: A settings access is a command byte followed by one data byte. In the command byte, bit 7 = 1 means read and 0 means write, and bits 4..0 give the address. The routing byte is at address 0 and resets to 0x00. The threshold byte is at address 1 and resets to 0x08. Any other address reads 0x00. On a read, the data byte returns the value on MISO.
- R4: The queue holds 16 bytes. A store while it is full is dropped. A take while it is empty has no effect, and an SPI read of an empty queue returns 0x00.
- R5: In receive mode, irq0 follows routing bits 7..6: 00 gives 0, 01 gives the stored-byte pulse, 10 gives queue not empty, 11 gives start_det.
- R6: In transmit mode, irq0 follows routing bit 3: 1 gives the low-level flag, 0 gives queue not empty.
- R7: In receive mode, irq1 follows routing bits 5..4: 00 gives 0, 01 gives queue full, 10 gives rssi_irq, 11 gives the high-level flag.
- R8: In transmit mode, irq1 follows routing bit 2: 0 gives queue full, 1 gives tx_stop.
- R9: The stored-byte pulse is high for exactly one clock after each receive-side byte that the queue accepts. A byte dropped because the queue is full gives no pulse.
- R10: The low-level flag is set while the fill count is below the threshold byte. The high-level flag is set while the fill count is at or above it.
- R11: After reset, both interrupt outputs are low and the queue is empty.
- R12: The queue is first-in first-out. In receive mode rx_push stores and SPI reads take. In transmit mode SPI writes store, tx_pop takes, and tx_data shows the head byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_sclk | input | 1 | SPI clock from host |
| spi_mosi | input | 1 | SPI data from host |
| spi_miso | output | 1 | SPI data to host |
| sel_fifo_n | input | 1 | Active-low select for the byte queue |
| sel_cfg_n | input | 1 | Active-low select for the settings |
| tx_mode | input | 1 | 1 = transmit, 0 = receive |
| rx_push | input | 1 | Demodulator stores rx_data (receive mode) |
| rx_data | input | 8 | Received byte |
| tx_pop | input | 1 | Modulator takes the head byte (transmit mode) |
| tx_data | output | 8 | Head byte in transmit mode, else 0 |
| start_det | input | 1 | Start-pattern hit |
| rssi_irq | input | 1 | Signal-strength alarm |
| tx_stop | input | 1 | Transmission finished |
| irq0 | output | 1 | Routed interrupt 0 |
| irq1 | output | 1 | Routed interrupt 1 |

## Verification
The bound checker checks on every cycle that the fill count stays in range and moves by at most one per cycle. It also checks that a full queue never accepts a store, that an empty queue never underflows, and that the off codes and the transmit queue-flag selections drive the pins as mapped. The bench scenarios cover the rest. These are bit order and partial-byte rejection on the serial side, select priority, the single-cycle stored-byte pulse, threshold crossings, end-to-end byte order through both directions, and readback of the settings.

// File: rtl/spr_pkg.sv
package spr_pkg;

    typedef enum logic [1:0] {
        TGT_NONE = 2'd0,
        TGT_FIFO = 2'd1,
        TGT_CFG  = 2'd2
    } spi_tgt_e;

    localparam int          CFG_REGS   = 2;
    localparam int          CFG_AW     = 5;
    localparam logic [4:0]  REG_ROUTE  = 5'd0;
    localparam logic [4:0]  REG_THR    = 5'd1;
    localparam logic [7:0]  ROUTE_RST  = 8'h00;
    localparam logic [7:0]  THR_RST    = 8'h08;

    // routing byte bits 7..2, in that order
    typedef struct packed {
        logic [1:0] rx0_sel;
        logic [1:0] rx1_sel;
        logic       tx0_sel;
        logic       tx1_sel;
    } route_t;

    typedef struct packed {
        logic wr_byte;
        logic not_empty;
        logic start_det;
        logic tx_thr;
        logic full;
        logic rssi;
        logic rx_thr;
        logic tx_stop;
    } irq_src_t;

    function automatic spi_tgt_e pick_target(input logic cfg_n, input logic fifo_n);
        if (!cfg_n)       return TGT_CFG;
        else if (!fifo_n) return TGT_FIFO;
        else              return TGT_NONE;
    endfunction

    function automatic logic [7:0] reg_reset(input int idx);
        if (idx == int'(REG_THR)) return THR_RST;
        return ROUTE_RST;
    endfunction

endpackage

// File: rtl/spr_spi_slave.sv
module spr_spi_slave
    import spr_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int BW          = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          sclk,
    input  logic          mosi,
    input  logic          sel_fifo_n,
    input  logic          sel_cfg_n,
    input  logic [BW-1:0] load_data,
    output logic          miso,
    output spi_tgt_e      target,
    output logic          at_first,
    output logic          byte_done,
    output logic          byte_first,
    output spi_tgt_e      byte_tgt,
    output logic [BW-1:0] byte_data
);
    localparam int CNTW = $clog2(BW);
    localparam int IX_SCLK = 3;
    localparam int IX_MOSI = 2;
    localparam int IX_FIFO = 1;
    localparam int IX_CFG  = 0;
    localparam logic [3:0] SYNC_IDLE = 4'b0011;

    logic [3:0]      sync_q [SYNC_STAGES];
    logic [3:0]      s;
    logic            sclk_d;
    logic            rise, fall;
    spi_tgt_e        tgt_now, tgt_q;
    logic [CNTW-1:0] bit_cnt;
    logic [BW-2:0]   rx_sh;
    logic [BW-1:0]   tx_sh;
    logic            load_arm, load_req;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < SYNC_STAGES; i++) sync_q[i] <= SYNC_IDLE;
        end else begin
            sync_q[0] <= {sclk, mosi, sel_fifo_n, sel_cfg_n};
            for (int i = 1; i < SYNC_STAGES; i++) sync_q[i] <= sync_q[i-1];
        end
    end

    assign s       = sync_q[SYNC_STAGES-1];
    assign rise    = s[IX_SCLK] & ~sclk_d;
    assign fall    = ~s[IX_SCLK] & sclk_d;
    assign tgt_now = pick_target(s[IX_CFG], s[IX_FIFO]);

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_d     <= 1'b0;
            tgt_q      <= TGT_NONE;
            bit_cnt    <= '0;
            rx_sh      <= '0;
            tx_sh      <= '0;
            at_first   <= 1'b1;
            byte_done  <= 1'b0;
            byte_first <= 1'b0;
            byte_tgt   <= TGT_NONE;
            byte_data  <= '0;
            load_arm   <= 1'b0;
            load_req   <= 1'b0;
        end else begin
            sclk_d    <= s[IX_SCLK];
            tgt_q     <= tgt_now;
            byte_done <= 1'b0;
            load_arm  <= 1'b0;
            load_req  <= load_arm;
            if (tgt_now != tgt_q) begin
                bit_cnt  <= '0;
                at_first <= 1'b1;
                load_arm <= (tgt_now != TGT_NONE);
            end else if (tgt_q != TGT_NONE && rise) begin
                rx_sh <= {rx_sh[BW-3:0], s[IX_MOSI]};
                if (bit_cnt == CNTW'(BW-1)) begin
                    bit_cnt    <= '0;
                    byte_done  <= 1'b1;
                    byte_first <= at_first;
                    byte_tgt   <= tgt_q;
                    byte_data  <= {rx_sh, s[IX_MOSI]};
                    at_first   <= 1'b0;
                    load_arm   <= 1'b1;
                end else begin
                    bit_cnt <= bit_cnt + 1'b1;
                end
            end
            if (load_req) begin
                tx_sh <= load_data;
            end else if (fall && tgt_q != TGT_NONE && bit_cnt != '0) begin
                tx_sh <= {tx_sh[BW-2:0], 1'b0};
            end
        end
    end

    assign miso   = (tgt_q != TGT_NONE) & tx_sh[BW-1];
    assign target = tgt_q;

endmodule

// File: rtl/spr_byte_fifo.sv
module spr_byte_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 16,
    parameter int AW    = $clog2(DEPTH),
    parameter int CW    = AW + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  logic [W-1:0]  wdata,
    input  logic          pop,
    output logic [W-1:0]  rdata,
    output logic [CW-1:0] count,
    output logic          full,
    output logic          empty
);
    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic          do_push, do_pop;

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push & ~full;
    assign do_pop  = pop & ~empty;
    assign rdata   = mem[rd_ptr];

    function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
        return (p == AW'(DEPTH-1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= step(wr_ptr);
            if (do_pop)  rd_ptr <= step(rd_ptr);
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

endmodule

// File: rtl/spr_cfg_regs.sv
module spr_cfg_regs
    import spr_pkg::*;
#(
    parameter int NREG = CFG_REGS,
    parameter int AW   = CFG_AW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [7:0]    wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [7:0]    rd_data,
    output logic [7:0]    route,
    output logic [7:0]    thr
);
    logic [7:0] regs_q [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst)                                regs_q[g] <= reg_reset(g);
            else if (wr_en && wr_addr == AW'(g))    regs_q[g] <= wr_data;
        end
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NREG; i++) begin
            if (rd_addr == AW'(i)) rd_data = regs_q[i];
        end
    end

    assign route = regs_q[int'(REG_ROUTE)];
    assign thr   = regs_q[int'(REG_THR)];

endmodule

// File: rtl/spr_irq_mux.sv
module spr_irq_mux
    import spr_pkg::*;
(
    input  logic     tx_mode,
    input  route_t   sel,
    input  irq_src_t src,
    output logic     irq0,
    output logic     irq1
);
    always_comb begin
        if (tx_mode) begin
            irq0 = sel.tx0_sel ? src.tx_thr  : src.not_empty;
            irq1 = sel.tx1_sel ? src.tx_stop : src.full;
        end else begin
            case (sel.rx0_sel)
                2'b00:   irq0 = 1'b0;
                2'b01:   irq0 = src.wr_byte;
                2'b10:   irq0 = src.not_empty;
                default: irq0 = src.start_det;
            endcase
            case (sel.rx1_sel)
                2'b00:   irq1 = 1'b0;
                2'b01:   irq1 = src.full;
                2'b10:   irq1 = src.rssi;
                default: irq1 = src.rx_thr;
            endcase
        end
    end
endmodule

// File: rtl/spi_irq_router.sv
module spi_irq_router
    import spr_pkg::*;
#(
    parameter int DEPTH       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       spi_sclk,
    input  logic       spi_mosi,
    output logic       spi_miso,
    input  logic       sel_fifo_n,
    input  logic       sel_cfg_n,
    input  logic       tx_mode,
    input  logic       rx_push,
    input  logic [7:0] rx_data,
    input  logic       tx_pop,
    output logic [7:0] tx_data,
    input  logic       start_det,
    input  logic       rssi_irq,
    input  logic       tx_stop,
    output logic       irq0,
    output logic       irq1
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = AW + 1;

    spi_tgt_e    spi_tgt, byte_tgt;
    logic        at_first, byte_done, byte_first;
    logic [7:0]  byte_data, load_data;

    logic        fifo_push, fifo_pop, fifo_full, fifo_empty;
    logic [7:0]  fifo_wdata, fifo_head;
    logic [CW-1:0] fifo_count;

    logic        cmd_rd, cmd_live;
    logic [CFG_AW-1:0] cmd_addr;
    logic        cfg_done, cfg_we;
    logic [7:0]  cfg_rdata, route_q, thr_q;

    logic        wr_pulse;
    irq_src_t    src;
    route_t      route_sel;

    spr_spi_slave #(.SYNC_STAGES(SYNC_STAGES), .BW(8)) u_spi (
        .clk        (clk),
        .rst        (rst),
        .sclk       (spi_sclk),
        .mosi       (spi_mosi),
        .sel_fifo_n (sel_fifo_n),
        .sel_cfg_n  (sel_cfg_n),
        .load_data  (load_data),
        .miso       (spi_miso),
        .target     (spi_tgt),
        .at_first   (at_first),
        .byte_done  (byte_done),
        .byte_first (byte_first),
        .byte_tgt   (byte_tgt),
        .byte_data  (byte_data)
    );

    // queue direction follows the mode
    logic spi_fifo_done;
    assign spi_fifo_done = byte_done && (byte_tgt == TGT_FIFO);
    assign fifo_push  = tx_mode ? spi_fifo_done : rx_push;
    assign fifo_wdata = tx_mode ? byte_data     : rx_data;
    assign fifo_pop   = tx_mode ? tx_pop        : spi_fifo_done;

    spr_byte_fifo #(.W(8), .DEPTH(DEPTH)) u_fifo (
        .clk   (clk),
        .rst   (rst),
        .push  (fifo_push),
        .wdata (fifo_wdata),
        .pop   (fifo_pop),
        .rdata (fifo_head),
        .count (fifo_count),
        .full  (fifo_full),
        .empty (fifo_empty)
    );

    // settings transaction: command byte then one data byte
    assign cfg_done = byte_done && (byte_tgt == TGT_CFG);
    assign cfg_we   = cfg_done && !byte_first && cmd_live && !cmd_rd;

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_rd   <= 1'b0;
            cmd_addr <= '0;
            cmd_live <= 1'b0;
        end else if (cfg_done) begin
            if (byte_first) begin
                cmd_rd   <= byte_data[7];
                cmd_addr <= byte_data[CFG_AW-1:0];
                cmd_live <= 1'b1;
            end else begin
                cmd_live <= 1'b0;
            end
        end
    end

    spr_cfg_regs #(.NREG(CFG_REGS), .AW(CFG_AW)) u_cfg (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (cfg_we),
        .wr_addr (cmd_addr),
        .wr_data (byte_data),
        .rd_addr (cmd_addr),
        .rd_data (cfg_rdata),
        .route   (route_q),
        .thr     (thr_q)
    );

    always_comb begin
        case (spi_tgt)
            TGT_FIFO: load_data = (!tx_mode && !fifo_empty) ? fifo_head : 8'h00;
            TGT_CFG:  load_data = (!at_first && cmd_live && cmd_rd) ? cfg_rdata : 8'h00;
            default:  load_data = 8'h00;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) wr_pulse <= 1'b0;
        else     wr_pulse <= !tx_mode && rx_push && !fifo_full;
    end

    assign src.wr_byte   = wr_pulse;
    assign src.not_empty = !fifo_empty;
    assign src.start_det = start_det;
    assign src.tx_thr    = {{(8-CW){1'b0}}, fifo_count} <  thr_q;
    assign src.full      = fifo_full;
    assign src.rssi      = rssi_irq;
    assign src.rx_thr    = {{(8-CW){1'b0}}, fifo_count} >= thr_q;
    assign src.tx_stop   = tx_stop;
    assign route_sel     = route_t'(route_q[7:2]);

    spr_irq_mux u_irq (
        .tx_mode (tx_mode),
        .sel     (route_sel),
        .src     (src),
        .irq0    (irq0),
        .irq1    (irq1)
    );

    assign tx_data = (tx_mode && !fifo_empty) ? fifo_head : 8'h00;

endmodule

// File: rtl/spi_irq_router_chk.sv
module spi_irq_router_chk #(
    parameter int DEPTH = 16,
    parameter int CW    = $clog2(DEPTH) + 1
) (
    input logic          clk,
    input logic          rst,
    input logic          tx_mode,
    input logic [5:0]    route,
    input logic          irq0,
    input logic          irq1,
    input logic [CW-1:0] fifo_count,
    input logic          fifo_full,
    input logic          fifo_empty,
    input logic          fifo_push,
    input logic          fifo_pop
);
    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        fifo_count <= CW'(DEPTH)); // R4
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        (fifo_full && fifo_push && !fifo_pop) |=> fifo_full); // R4
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
        (fifo_empty && fifo_pop && !fifo_push) |=> fifo_empty); // R4
    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
        (fifo_count == $past(fifo_count)) || (fifo_count == $past(fifo_count) + 1'b1)
        || (fifo_count + 1'b1 == $past(fifo_count))); // R12
    AST_RX0_OFF: assert property (@(posedge clk) disable iff (rst)
        (!tx_mode && route[5:4] == 2'b00) |-> !irq0); // R5
    AST_RX1_OFF: assert property (@(posedge clk) disable iff (rst)
        (!tx_mode && route[3:2] == 2'b00) |-> !irq1); // R7
    AST_TX0_AVAIL: assert property (@(posedge clk) disable iff (rst)
        (tx_mode && !route[1]) |-> (irq0 == !fifo_empty)); // R6
    AST_TX1_FULL: assert property (@(posedge clk) disable iff (rst)
        (tx_mode && !route[0]) |-> (irq1 == fifo_full)); // R8
endmodule

bind spi_irq_router spi_irq_router_chk #(.DEPTH(DEPTH)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .tx_mode    (tx_mode),
    .route      (route_q[7:2]),
    .irq0       (irq0),
    .irq1       (irq1),
    .fifo_count (fifo_count),
    .fifo_full  (fifo_full),
    .fifo_empty (fifo_empty),
    .fifo_push  (fifo_push),
    .fifo_pop   (fifo_pop)
);

// File: tb/spi_irq_router_bench.sv
`timescale 1ns/1ps
module spi_irq_router_bench;
    localparam int HALF = 6;

    logic clk = 1'b0;
    logic rst;
    logic spi_sclk, spi_mosi, spi_miso, sel_fifo_n, sel_cfg_n, tx_mode;
    logic rx_push, tx_pop, start_det, rssi_irq, tx_stop, irq0, irq1;
    logic [7:0] rx_data, tx_data;

    int n_total = 0;
    int n_fail  = 0;
    bit finished = 1'b0;
    logic [7:0] exp_q [$];
    logic [7:0] rd;

    always #10 clk = ~clk;

    spi_irq_router u_spi_irq_router (
        .clk(clk), .rst(rst), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_miso(spi_miso),
        .sel_fifo_n(sel_fifo_n), .sel_cfg_n(sel_cfg_n), .tx_mode(tx_mode),
        .rx_push(rx_push), .rx_data(rx_data), .tx_pop(tx_pop), .tx_data(tx_data),
        .start_det(start_det), .rssi_irq(rssi_irq), .tx_stop(tx_stop),
        .irq0(irq0), .irq1(irq1)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_total++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    // scoreboard monitor: compare produced byte against oldest expected
    task automatic sb_check(input string req, input logic [7:0] act);
        logic [7:0] e;
        e = (exp_q.size() > 0) ? exp_q.pop_front() : 8'hxx;
        check(req, act, e);
    endtask

    // driver: store expectation only when the model queue has room
    task automatic sb_expect(input logic [7:0] b);
        if (exp_q.size() < 16) exp_q.push_back(b);
    endtask

    task automatic spi_shift(input logic [7:0] dout, input int nbits, output logic [7:0] din);
        din = 8'h00;
        for (int i = 7; i > 7 - nbits; i--) begin
            spi_mosi = dout[i];
            repeat (HALF) @(negedge clk);
            din = {din[6:0], spi_miso};
            spi_sclk = 1'b1;
            repeat (HALF) @(negedge clk);
            spi_sclk = 1'b0;
        end
    endtask

    task automatic sel_open(input logic cfg, input logic fifo);
        @(negedge clk);
        sel_cfg_n  = ~cfg;
        sel_fifo_n = ~fifo;
        repeat (10) @(negedge clk);
    endtask

    task automatic sel_close();
        repeat (10) @(negedge clk);
        sel_cfg_n  = 1'b1;
        sel_fifo_n = 1'b1;
        repeat (10) @(negedge clk);
    endtask

    task automatic cfg_write(input logic [4:0] a, input logic [7:0] d);
        logic [7:0] dummy;
        sel_open(1'b1, 1'b0);
        spi_shift({3'b000, a}, 8, dummy);
        spi_shift(d, 8, dummy);
        sel_close();
    endtask

    task automatic cfg_read(input logic [4:0] a, output logic [7:0] d);
        logic [7:0] dummy;
        sel_open(1'b1, 1'b0);
        spi_shift({3'b100, a}, 8, dummy);
        spi_shift(8'h00, 8, d);
        sel_close();
    endtask

    task automatic radio_push(input logic [7:0] b);
        @(negedge clk);
        rx_push = 1'b1;
        rx_data = b;
        @(negedge clk);
        rx_push = 1'b0;
        sb_expect(b);
    endtask

    task automatic spi_drain(input int n, input string req);
        logic [7:0] d;
        sel_open(1'b0, 1'b1);
        for (int i = 0; i < n; i++) begin
            spi_shift(8'h00, 8, d);
            sb_check(req, d);
        end
        sel_close();
    endtask

    task automatic spi_fill(input int n, input logic [7:0] base);
        logic [7:0] d;
        sel_open(1'b0, 1'b1);
        for (int i = 0; i < n; i++) begin
            spi_shift(base + 8'(i * 13), 8, d);
            sb_expect(base + 8'(i * 13));
        end
        sel_close();
    endtask

    task automatic modem_take(input string req);
        @(negedge clk);
        sb_check(req, tx_data);
        tx_pop = 1'b1;
        @(negedge clk);
        tx_pop = 1'b0;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            n_total++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=done");
            $display("%0d/%0d checks passed", n_total - n_fail, n_total);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; spi_sclk = 1'b0; spi_mosi = 1'b0; sel_fifo_n = 1'b1; sel_cfg_n = 1'b1;
        tx_mode = 1'b0; rx_push = 1'b0; rx_data = 8'h00; tx_pop = 1'b0;
        start_det = 1'b0; rssi_irq = 1'b0; tx_stop = 1'b0;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (3) @(negedge clk);

        // R11 reset state
        check("R11 irq0", {7'd0, irq0}, 8'h00);
        check("R11 irq1", {7'd0, irq1}, 8'h00);

        // R3 reset values, unused address, write/readback
        cfg_read(5'd0, rd);  check("R3 route reset", rd, 8'h00);
        cfg_read(5'd1, rd);  check("R3 thr reset", rd, 8'h08);
        cfg_read(5'd9, rd);  check("R3 unused addr", rd, 8'h00);
        cfg_write(5'd0, 8'h90);
        cfg_read(5'd0, rd);  check("R3 route readback", rd, 8'h90);

        // R5 not-empty on irq0, R12 order through SPI reads
        check("R5 irq0 empty", {7'd0, irq0}, 8'h00);
        radio_push(8'hA5); radio_push(8'h3C); radio_push(8'hF0);
        check("R5 irq0 not empty", {7'd0, irq0}, 8'h01);
        check("R7 irq1 not full", {7'd0, irq1}, 8'h00);
        spi_drain(3, "R12 rx order");
        check("R5 irq0 drained", {7'd0, irq0}, 8'h00);

        // R4 read of empty queue
        spi_drain(0, "R4");
        sel_open(1'b0, 1'b1);
        spi_shift(8'h00, 8, rd);
        sel_close();
        check("R4 empty read", rd, 8'h00);
        check("R4 empty stays", {7'd0, irq0}, 8'h00);

        // R4 overflow drop, R7 full on irq1
        for (int i = 0; i < 17; i++) radio_push(8'(i * 7 + 1));
        check("R7 irq1 full", {7'd0, irq1}, 8'h01);
        spi_drain(16, "R4 full order");
        check("R4 extra dropped", {7'd0, irq0}, 8'h00);
        check("R7 irq1 not full", {7'd0, irq1}, 8'h00);

        // R9 stored-byte pulse
        cfg_write(5'd0, 8'h40);
        @(negedge clk); rx_push = 1'b1; rx_data = 8'h11;
        @(negedge clk); rx_push = 1'b0; sb_expect(8'h11);
        check("R9 pulse high", {7'd0, irq0}, 8'h01);
        @(negedge clk);
        check("R9 pulse one cycle", {7'd0, irq0}, 8'h00);
        for (int i = 0; i < 15; i++) radio_push(8'(8'h20 + i));
        @(negedge clk); rx_push = 1'b1; rx_data = 8'hEE;
        @(negedge clk); rx_push = 1'b0;
        check("R9 no pulse when full", {7'd0, irq0}, 8'h00);
        @(negedge clk);
        check("R9 no pulse when full", {7'd0, irq0}, 8'h00);
        spi_drain(16, "R12 rx order");

        // R5 start_det, R7 rssi
        cfg_write(5'd0, 8'hE0);
        @(negedge clk); start_det = 1'b1; @(negedge clk);
        check("R5 start_det", {7'd0, irq0}, 8'h01);
        rssi_irq = 1'b1; @(negedge clk);
        check("R7 rssi", {7'd0, irq1}, 8'h01);
        start_det = 1'b0; rssi_irq = 1'b0; @(negedge clk);
        check("R5 start_det low", {7'd0, irq0}, 8'h00);

        // R10 high-level flag on irq1
        cfg_write(5'd0, 8'h30);
        for (int i = 0; i < 7; i++) radio_push(8'(8'h40 + i));
        check("R10 below thr", {7'd0, irq1}, 8'h00);
        radio_push(8'h47);
        check("R10 at thr", {7'd0, irq1}, 8'h01);
        spi_drain(8, "R12 rx order");

        // R5 R7 off codes
        cfg_write(5'd0, 8'h00);
        @(negedge clk); start_det = 1'b1; rssi_irq = 1'b1; @(negedge clk);
        check("R5 off", {7'd0, irq0}, 8'h00);
        check("R7 off", {7'd0, irq1}, 8'h00);
        start_det = 1'b0; rssi_irq = 1'b0;

        // transmit direction
        tx_mode = 1'b1;
        repeat (4) @(negedge clk);
        check("R6 irq0 empty", {7'd0, irq0}, 8'h00);
        spi_fill(2, 8'h5A);
        check("R6 irq0 not empty", {7'd0, irq0}, 8'h01);
        modem_take("R12 tx order");
        modem_take("R12 tx order");
        check("R6 irq0 drained", {7'd0, irq0}, 8'h00);

        spi_fill(17, 8'h01);
        check("R8 irq1 full", {7'd0, irq1}, 8'h01);
        for (int i = 0; i < 16; i++) modem_take("R4 tx order");
        check("R4 tx extra dropped", {7'd0, irq0}, 8'h00);
        check("R8 irq1 not full", {7'd0, irq1}, 8'h00);

        // R6 low-level flag, R8 tx_stop, R10
        cfg_write(5'd0, 8'h0C);
        check("R10 low level empty", {7'd0, irq0}, 8'h01);
        @(negedge clk); tx_stop = 1'b1; @(negedge clk);
        check("R8 tx_stop", {7'd0, irq1}, 8'h01);
        tx_stop = 1'b0; @(negedge clk);
        check("R8 tx_stop low", {7'd0, irq1}, 8'h00);
        spi_fill(8, 8'h80);
        check("R10 at thr", {7'd0, irq0}, 8'h00);
        modem_take("R12 tx order");
        check("R10 below thr", {7'd0, irq0}, 8'h01);
        for (int i = 0; i < 7; i++) modem_take("R12 tx order");

        // R4 take from empty
        cfg_write(5'd0, 8'h00);
        @(negedge clk); tx_pop = 1'b1; @(negedge clk); tx_pop = 1'b0; @(negedge clk);
        check("R4 empty take", {7'd0, irq0}, 8'h00);

        // R2 partial byte discarded, then a clean byte
        sel_open(1'b0, 1'b1);
        spi_shift(8'hFF, 5, rd);
        sel_close();
        check("R2 partial discarded", {7'd0, irq0}, 8'h00);
        spi_fill(1, 8'h96);
        check("R2 full byte stored", {7'd0, irq0}, 8'h01);
        modem_take("R2 msb first");

        // R1 both selects low: settings win
        sel_open(1'b1, 1'b1);
        spi_shift(8'h01, 8, rd);
        spi_shift(8'h05, 8, rd);
        sel_close();
        check("R1 queue untouched", {7'd0, irq0}, 8'h00);
        cfg_read(5'd1, rd);
        check("R1 settings written", rd, 8'h05);

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end
endmodule